// File: doc/BRIEF.md
# Bypassable Multistage Decimation Chain

This block lowers the sample rate of a complex baseband stream that has already been shifted to DC. It runs the stream through a cascade of four FIR decimators: two half-band stages that each halve the rate, then two 19-tap symmetric stages that divide by 3 and then by 2. A two-bit mode input chooses the input bandwidth. In the widest mode every stage runs. In the middle mode the first stage is bypassed, and in the narrowest mode the first two are bypassed. Every mode therefore ends at the same 1.28 MS/s output rate and gives the same output count per capture.

Input samples arrive with a valid strobe and a block-start flag. The block-start flag clears every stage's history and decimation phase. This keeps one capture from bleeding into the next, and it lets the block produce exactly the block length divided by the decimation factor. The mode is sampled on the first sample of each block. Coefficients are elaboration-time parameters, and each stage rounds and saturates its result back to the data width.

Top module: `rach_decim_chain`

## Requirements
- R1: With mode code 0, all four stages run in series, decimating by 2, 2, 3 and 2, for an overall factor of 24.
- R2: With mode code 1, the first half-band stage is bypassed and the overall factor is 12.
- R3: With mode code 2 or 3, both half-band stages are bypassed and the overall factor is 6.
- R4: Each running stage emits one output on every FACTOR-th input of the block, counting from 1. Tap 0 multiplies the newest stage input and samples before the block start count as zero. The sum is scaled by 2^-FRAC (FRAC=15) with round-half-up (add 2^(FRAC-1), then floor). I and Q are filtered independently with the same coefficients.
- R5: A scaled stage result above 2^(DW-1)-1 is clipped to 2^(DW-1)-1. A result below -2^(DW-1) is clipped to -2^(DW-1).
- R6: A sample with in_first=1 clears all stage histories and phases. The first output of each block carries out_first=1 and every other output carries out_first=0.
- R7: A block of N input samples, with N a multiple of the mode's factor, gives exactly N/factor outputs. In mode 0, 24576 inputs give 1024 outputs and 49152 inputs give 2048 outputs.
- R8: Idle cycles between input samples do not change the results. Every output appears at most 4 cycles after an accepted input sample.
- R9: mode_sel is sampled only together with a valid block-start sample. A change during the rest of the block has no effect on that block.
- R10: After reset, out_valid and out_first are 0 and out_i and out_q are 0 until the first output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Bandwidth mode: 0 widest, 1 middle, 2 or 3 narrowest |
| in_valid | input | 1 | Input sample strobe |
| in_first | input | 1 | Marks the first sample of a block |
| in_i | input | DW | In-phase input sample, signed |
| in_q | input | DW | Quadrature input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_first | output | 1 | Marks the first output of a block |
| out_i | output | DW | In-phase output sample, signed |
| out_q | output | DW | Quadrature output sample, signed |

## Verification
Independent random I and Q streams of full capture length in each mode show whether the right stages are bypassed and whether the lanes are kept apart. The expected output of each mode is computed by direct convolution in the bench. A step to the rails shows whether overshoot is clipped or wraps, and a slowed stream with idle gaps shows whether results depend on sample timing. Back-to-back blocks that start after a large constant block show whether history leaks across the start flag, and a mode change in the middle of a block shows whether the mode is sampled only once per block.

// File: rtl/rach_dec_pkg.sv
`timescale 1ns/1ps
package rach_dec_pkg;
   typedef enum logic [1:0] {
      BW_WIDE   = 2'd0,
      BW_MID    = 2'd1,
      BW_NARROW = 2'd2,
      BW_NARROW_ALT = 2'd3
   } bw_mode_e;

   localparam int DEC_S1 = 2;
   localparam int DEC_S2 = 2;
   localparam int DEC_S3 = 3;
   localparam int DEC_S4 = 2;

   // stage index 1 or 2: is that leading stage in use for the mode
   function automatic logic lead_stage_on(bw_mode_e m, int idx);
      if (idx == 1) return (m == BW_WIDE);
      return (m == BW_WIDE) || (m == BW_MID);
   endfunction
endpackage

// File: rtl/dec_clip.sv
`timescale 1ns/1ps
module dec_clip #(
   parameter int AW   = 36,
   parameter int DW   = 16,
   parameter int FRAC = 15
) (
   input  logic signed [AW-1:0] acc,
   output logic signed [DW-1:0] y,
   output logic                 over_hi,
   output logic                 over_lo
);
   localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC-1);
   localparam logic signed [AW-1:0] MAXW = AW'((1 <<< (DW-1)) - 1);
   localparam logic signed [AW-1:0] MINW = -(AW'(1) <<< (DW-1));

   logic signed [AW-1:0] rnd;

   initial begin
      if (FRAC < 1 || FRAC >= AW - DW) $error("dec_clip: FRAC out of range");
   end

   always_comb begin
      rnd     = (acc + HALF) >>> FRAC;
      over_hi = (rnd > MAXW);
      over_lo = (rnd < MINW);
      if (over_hi)      y = MAXW[DW-1:0];
      else if (over_lo) y = MINW[DW-1:0];
      else              y = rnd[DW-1:0];
   end
endmodule

// File: rtl/dec_stage.sv
`timescale 1ns/1ps
module dec_stage #(
   parameter int NTAP     = 7,
   parameter int FACTOR   = 2,
   parameter bit HALFBAND = 1'b1,
   parameter int DW       = 16,
   parameter int CW       = 16,
   parameter int FRAC     = 15,
   parameter int COEF [NTAP] = '{default: 0}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_first,
   input  logic signed [DW-1:0] in_i,
   input  logic signed [DW-1:0] in_q,
   output logic                 out_valid,
   output logic                 out_first,
   output logic signed [DW-1:0] out_i,
   output logic signed [DW-1:0] out_q
);
   localparam int MID = (NTAP - 1) / 2;
   localparam int PW  = (FACTOR > 2) ? $clog2(FACTOR) : 1;
   localparam int AW  = DW + CW + $clog2(NTAP) + 2;
   localparam logic signed [DW-1:0] MAXV = DW'((1 <<< (DW-1)) - 1);
   localparam logic signed [DW-1:0] MINV = DW'(1 <<< (DW-1));

   // elaboration checks
   if (NTAP < 3 || (NTAP % 2) == 0) begin : g_bad_len
      $error("dec_stage: NTAP must be odd and at least 3");
   end
   if (FACTOR < 2) begin : g_bad_fac
      $error("dec_stage: FACTOR must be at least 2");
   end
   for (genvar c = 0; c < MID; c++) begin : g_coef_chk
      if (COEF[c] != COEF[NTAP-1-c]) begin : g_asym
         $error("dec_stage: coefficients not symmetric");
      end
      if (HALFBAND && ((MID - c) % 2 == 0) && COEF[c] != 0) begin : g_hb_nz
         $error("dec_stage: half-band zero tap is not zero");
      end
   end

   logic signed [DW-1:0] smp  [2];
   logic signed [DW-1:0] hist [2][NTAP-1];
   logic signed [AW-1:0] term [2][MID+1];
   logic signed [AW-1:0] acc  [2];
   logic signed [DW-1:0] yv   [2];
   logic                 hi   [2];
   logic                 lo   [2];
   logic [PW-1:0]        phase, eff_ph;
   logic                 hit, pend;

   assign smp[0] = in_i;
   assign smp[1] = in_q;

   for (genvar l = 0; l < 2; l++) begin : g_lane
      for (genvar j = 0; j < MID; j++) begin : g_pair
         if (HALFBAND && ((MID - j) % 2 == 0)) begin : g_skip
            assign term[l][j] = '0;
         end else begin : g_mul
            localparam logic signed [CW-1:0] CJ = CW'(COEF[j]);
            logic signed [DW-1:0] a, b;
            logic signed [DW:0]   pre;
            if (j == 0) begin : g_new
               assign a = smp[l];
            end else begin : g_old
               assign a = in_first ? '0 : hist[l][j-1];
            end
            assign b   = in_first ? '0 : hist[l][NTAP-2-j];
            assign pre = {a[DW-1], a} + {b[DW-1], b};
            assign term[l][j] = AW'(pre) * AW'(CJ);
         end
      end
      localparam logic signed [CW-1:0] CM = CW'(COEF[MID]);
      logic signed [DW-1:0] ctr;
      assign ctr = in_first ? '0 : hist[l][MID-1];
      assign term[l][MID] = AW'(ctr) * AW'(CM);

      always_comb begin
         acc[l] = '0;
         for (int k = 0; k <= MID; k++) acc[l] = acc[l] + term[l][k];
      end

      dec_clip #(.AW(AW), .DW(DW), .FRAC(FRAC)) u_clip (
         .acc(acc[l]), .y(yv[l]), .over_hi(hi[l]), .over_lo(lo[l])
      );
   end

   always_comb begin
      eff_ph = in_first ? '0 : phase;
      hit    = in_valid && (eff_ph == PW'(FACTOR - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_first <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
         phase     <= '0;
         pend      <= 1'b0;
         for (int l = 0; l < 2; l++)
            for (int k = 0; k < NTAP-1; k++) hist[l][k] <= '0;
      end else begin
         out_valid <= hit;
         if (hit) begin
            out_i     <= yv[0];
            out_q     <= yv[1];
            out_first <= in_first | pend;
            pend      <= 1'b0;
         end else begin
            out_first <= 1'b0;
            if (in_valid && in_first) pend <= 1'b1;
         end
         if (in_valid) begin
            phase <= hit ? '0 : eff_ph + 1'b1;
            for (int l = 0; l < 2; l++) begin
               hist[l][0] <= smp[l];
               for (int k = 1; k < NTAP-1; k++)
                  hist[l][k] <= in_first ? '0 : hist[l][k-1];
            end
         end
      end
   end

   // R4: one output per FACTOR inputs, so outputs never come on adjacent cycles
   p_out_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R6: a block-start sample can never complete a decimation group
   p_first_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_first) |=> !out_valid);

   // R5: an over-range result lands on the rail
   p_clip_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && hi[0]) |=> (out_i == MAXV));
   p_clip_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && lo[1]) |=> (out_q == MINV));
endmodule

// File: rtl/rach_decim_chain.sv
`timescale 1ns/1ps
module rach_decim_chain
   import rach_dec_pkg::*;
#(
   parameter int DW   = 16,
   parameter int CW   = 16,
   parameter int FRAC = 15,
   parameter int HB1_COEF [7]  = '{-1024, 0, 9216, 16384, 9216, 0, -1024},
   parameter int HB2_COEF [11] = '{256, 0, -1536, 0, 9472, 16384, 9472, 0, -1536, 0, 256},
   parameter int SY3_COEF [19] = '{-80, -160, -120, 100, 600, 1400, 2500, 3600, 4400, 8288,
                                   4400, 3600, 2500, 1400, 600, 100, -120, -160, -80},
   parameter int SY4_COEF [19] = '{40, -60, -200, -250, 0, 600, 1500, 2700, 3800, 16508,
                                   3800, 2700, 1500, 600, 0, -250, -200, -60, 40}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           mode_sel,
   input  logic                 in_valid,
   input  logic                 in_first,
   input  logic signed [DW-1:0] in_i,
   input  logic signed [DW-1:0] in_q,
   output logic                 out_valid,
   output logic                 out_first,
   output logic signed [DW-1:0] out_i,
   output logic signed [DW-1:0] out_q
);
   localparam int MAX_LAT = 4;

   bw_mode_e mode_q, eff_mode;
   logic     en1, en2;

   logic                 v   [1:4];
   logic                 f   [1:4];
   logic signed [DW-1:0] di  [1:4];
   logic signed [DW-1:0] dq  [1:4];
   logic                 vin [1:4];
   logic                 fin [1:4];
   logic signed [DW-1:0] iin [1:4];
   logic signed [DW-1:0] qin [1:4];

   always_comb begin
      eff_mode = (in_valid && in_first) ? bw_mode_e'(mode_sel) : mode_q;
      en1 = lead_stage_on(eff_mode, 1);
      en2 = lead_stage_on(eff_mode, 2);

      vin[1] = in_valid & en1;  fin[1] = in_first;  iin[1] = in_i;  qin[1] = in_q;

      vin[2] = en2 & (en1 ? v[1] : in_valid);
      fin[2] = en1 ? f[1]  : in_first;
      iin[2] = en1 ? di[1] : in_i;
      qin[2] = en1 ? dq[1] : in_q;

      vin[3] = en2 ? v[2]  : in_valid;
      fin[3] = en2 ? f[2]  : in_first;
      iin[3] = en2 ? di[2] : in_i;
      qin[3] = en2 ? dq[2] : in_q;

      vin[4] = v[3];  fin[4] = f[3];  iin[4] = di[3];  qin[4] = dq[3];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   mode_q <= BW_WIDE;
      else if (in_valid && in_first) mode_q <= bw_mode_e'(mode_sel);
   end

   dec_stage #(.NTAP(7), .FACTOR(DEC_S1), .HALFBAND(1'b1), .DW(DW), .CW(CW),
               .FRAC(FRAC), .COEF(HB1_COEF)) u_s1 (
      .clk(clk), .rst_n(rst_n), .in_valid(vin[1]), .in_first(fin[1]),
      .in_i(iin[1]), .in_q(qin[1]),
      .out_valid(v[1]), .out_first(f[1]), .out_i(di[1]), .out_q(dq[1]));

   dec_stage #(.NTAP(11), .FACTOR(DEC_S2), .HALFBAND(1'b1), .DW(DW), .CW(CW),
               .FRAC(FRAC), .COEF(HB2_COEF)) u_s2 (
      .clk(clk), .rst_n(rst_n), .in_valid(vin[2]), .in_first(fin[2]),
      .in_i(iin[2]), .in_q(qin[2]),
      .out_valid(v[2]), .out_first(f[2]), .out_i(di[2]), .out_q(dq[2]));

   dec_stage #(.NTAP(19), .FACTOR(DEC_S3), .HALFBAND(1'b0), .DW(DW), .CW(CW),
               .FRAC(FRAC), .COEF(SY3_COEF)) u_s3 (
      .clk(clk), .rst_n(rst_n), .in_valid(vin[3]), .in_first(fin[3]),
      .in_i(iin[3]), .in_q(qin[3]),
      .out_valid(v[3]), .out_first(f[3]), .out_i(di[3]), .out_q(dq[3]));

   dec_stage #(.NTAP(19), .FACTOR(DEC_S4), .HALFBAND(1'b0), .DW(DW), .CW(CW),
               .FRAC(FRAC), .COEF(SY4_COEF)) u_s4 (
      .clk(clk), .rst_n(rst_n), .in_valid(vin[4]), .in_first(fin[4]),
      .in_i(iin[4]), .in_q(qin[4]),
      .out_valid(v[4]), .out_first(f[4]), .out_i(di[4]), .out_q(dq[4]));

   assign out_valid = v[4];
   assign out_first = f[4];
   assign out_i     = di[4];
   assign out_q     = dq[4];

   // checker state: cycles since the last accepted input sample
   logic [2:0] idle_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          idle_cnt <= 3'd7;
      else if (in_valid)   idle_cnt <= 3'd0;
      else if (idle_cnt != 3'd7) idle_cnt <= idle_cnt + 3'd1;
   end

   // R8: no output more than MAX_LAT cycles after the last input
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cnt >= 3'(MAX_LAT)) |-> !out_valid);

   // R6: the block-start marker rides only on a valid output
   p_first_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_first |-> out_valid);
endmodule

// File: tb/sim_rach_decim_chain.sv
`timescale 1ns/1ps
module sim_rach_decim_chain;
   typedef int ia_t[];

   localparam int C1 [7]  = '{-1024, 0, 9216, 16384, 9216, 0, -1024};
   localparam int C2 [11] = '{256, 0, -1536, 0, 9472, 16384, 9472, 0, -1536, 0, 256};
   localparam int C3 [19] = '{-80, -160, -120, 100, 600, 1400, 2500, 3600, 4400, 8288,
                              4400, 3600, 2500, 1400, 600, 100, -120, -160, -80};
   localparam int C4 [19] = '{40, -60, -200, -250, 0, 600, 1500, 2700, 3800, 16508,
                              3800, 2700, 1500, 600, 0, -250, -200, -60, 40};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode_sel = 2'd0;
   logic in_valid = 1'b0, in_first = 1'b0;
   logic signed [15:0] in_i = '0, in_q = '0;
   logic out_valid, out_first;
   logic signed [15:0] out_i, out_q;

   always #2 clk = ~clk;

   rach_decim_chain #(.HB1_COEF(C1), .HB2_COEF(C2), .SY3_COEF(C3), .SY4_COEF(C4)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
      .in_first(in_first), .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
      .out_first(out_first), .out_i(out_i), .out_q(out_q));

   int cap_i[$], cap_q[$], cap_f[$];
   int nchk = 0, nfail = 0;
   bit done = 0;

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         cap_i.push_back(int'(out_i));
         cap_q.push_back(int'(out_q));
         cap_f.push_back(int'(out_first));
      end
   end

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // ---- reference model written from the requirements ----
   function automatic int coef(int st, int k);
      case (st)
         1: return C1[k];
         2: return C2[k];
         3: return C3[k];
         default: return C4[k];
      endcase
   endfunction

   function automatic ia_t fir(ia_t x, int st);
      int nt, fac, n, idx;
      longint acc, r;
      ia_t y;
      nt  = (st == 1) ? 7 : (st == 2) ? 11 : 19;
      fac = (st == 3) ? 3 : 2;
      n   = x.size() / fac;
      y   = new[n];
      for (int m = 0; m < n; m++) begin
         acc = 0;
         for (int k = 0; k < nt; k++) begin
            idx = m * fac + fac - 1 - k;
            if (idx >= 0) acc += longint'(coef(st, k)) * longint'(x[idx]);
         end
         r = (acc + 64'sd16384) >>> 15;
         if (r > 32767) r = 32767;
         if (r < -32768) r = -32768;
         y[m] = int'(r);
      end
      return y;
   endfunction

   function automatic ia_t model(ia_t x, int mode);
      ia_t y = x;
      if (mode == 0) y = fir(y, 1);
      if (mode <= 1) y = fir(y, 2);
      y = fir(y, 3);
      y = fir(y, 4);
      return y;
   endfunction

   // ---- drivers ----
   task automatic drive(int mode, ia_t bi, ia_t bq, int gap, int sw_at, int sw_mode);
      for (int n = 0; n < bi.size(); n++) begin
         @(negedge clk);
         if (n == 0) mode_sel = 2'(mode);
         if (n == sw_at) mode_sel = 2'(sw_mode);
         in_valid = 1'b1;
         in_first = (n == 0);
         in_i = 16'(bi[n]);
         in_q = 16'(bq[n]);
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_first = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
   endtask

   task automatic drain();
      repeat (12) @(negedge clk);
   endtask

   task automatic check_seg(string rq, int base, ia_t ei, ia_t eq);
      int bad = 0, fbad = 0, at = -1;
      longint av = 0, ev = 0;
      for (int m = 0; m < ei.size(); m++) begin
         if (base + m >= cap_i.size()) begin
            bad++;
         end else begin
            if (cap_i[base+m] != ei[m] || cap_q[base+m] != eq[m]) begin
               if (at < 0) begin
                  at = m;
                  av = (cap_i[base+m] != ei[m]) ? cap_i[base+m] : cap_q[base+m];
                  ev = (cap_i[base+m] != ei[m]) ? ei[m] : eq[m];
               end
               bad++;
            end
            if (cap_f[base+m] != ((m == 0) ? 1 : 0)) fbad++;
         end
      end
      chk(bad == 0, rq, $sformatf("sample value at index %0d", at), av, ev);
      chk(fbad == 0, "R6", "out_first placement errors", fbad, 0);
   endtask

   function automatic ia_t rnd_block(int n, int span);
      ia_t x = new[n];
      for (int k = 0; k < n; k++) x[k] = int'($urandom_range(2 * span, 0)) - span;
      return x;
   endfunction

   // ---- scenarios ----
   task automatic t_reset();
      chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
      chk(out_first == 1'b0, "R10", "out_first after reset", out_first, 0);
      chk(out_i == 0 && out_q == 0, "R10", "out data after reset", out_i, 0);
   endtask

   task automatic t_wide_full();
      int base = cap_i.size();
      ia_t bi = rnd_block(24576, 20000), bq = rnd_block(24576, 20000);
      drive(0, bi, bq, 0, -1, 0);
      drain();
      chk(cap_i.size() - base == 1024, "R7", "wide mode 24576-sample count", cap_i.size() - base, 1024);
      check_seg("R1", base, model(bi, 0), model(bq, 0));
   endtask

   task automatic t_wide_double();
      int base = cap_i.size();
      ia_t bi = rnd_block(49152, 12000), bq = rnd_block(49152, 12000);
      drive(0, bi, bq, 0, -1, 0);
      drain();
      chk(cap_i.size() - base == 2048, "R7", "wide mode 49152-sample count", cap_i.size() - base, 2048);
      check_seg("R4", base, model(bi, 0), model(bq, 0));
   endtask

   task automatic t_mid();
      int base = cap_i.size();
      ia_t bi = new[24576], bq = new[24576];
      for (int k = 0; k < 24576; k++) begin
         bi[k] = ((k % 512) < 256) ? (k % 256) * 100 - 12800 : 12800 - (k % 256) * 100;
         bq[k] = -bi[k] / 2 + ((k % 7) * 311);
      end
      drive(1, bi, bq, 0, -1, 0);
      drain();
      chk(cap_i.size() - base == 2048, "R2", "middle mode count", cap_i.size() - base, 2048);
      check_seg("R2", base, model(bi, 1), model(bq, 1));
   endtask

   task automatic t_narrow();
      int base = cap_i.size();
      ia_t bi = rnd_block(6144, 25000), bq = rnd_block(6144, 25000);
      drive(2, bi, bq, 0, -1, 0);
      drain();
      chk(cap_i.size() - base == 1024, "R3", "narrow mode count", cap_i.size() - base, 1024);
      check_seg("R3", base, model(bi, 2), model(bq, 2));
   endtask

   task automatic t_narrow_alt();
      int base = cap_i.size();
      ia_t bi = rnd_block(240, 30000), bq = rnd_block(240, 30000);
      drive(3, bi, bq, 0, -1, 0);
      drain();
      chk(cap_i.size() - base == 40, "R3", "mode code 3 count", cap_i.size() - base, 40);
      check_seg("R3", base, model(bi, 3), model(bq, 3));
   endtask

   task automatic t_clip();
      int base = cap_i.size(), nhi = 0, nlo = 0;
      ia_t bi = new[600], bq = new[600];
      ia_t ei, eq;
      for (int k = 0; k < 600; k++) begin
         bi[k] = (k < 100 || (k >= 300 && k < 400)) ? -32768 : 32767;
         bq[k] = -bi[k] - 1;
      end
      drive(2, bi, bq, 0, -1, 0);
      drain();
      ei = model(bi, 2);
      eq = model(bq, 2);
      check_seg("R5", base, ei, eq);
      for (int m = base; m < cap_i.size(); m++) begin
         if (cap_i[m] == 32767) nhi++;
         if (cap_q[m] == -32768) nlo++;
      end
      chk(nhi > 0, "R5", "outputs at upper rail", nhi, 1);
      chk(nlo > 0, "R5", "outputs at lower rail", nlo, 1);
   endtask

   task automatic t_isolation();
      int base = cap_i.size();
      ia_t ai = new[300], aq = new[300];
      ia_t bi = rnd_block(240, 15000), bq = rnd_block(240, 15000);
      for (int k = 0; k < 300; k++) begin
         ai[k] = 25000;
         aq[k] = -25000;
      end
      drive(1, ai, aq, 0, -1, 0);
      drive(1, bi, bq, 0, -1, 0);
      drain();
      chk(cap_i.size() - base == 45, "R6", "back-to-back total count", cap_i.size() - base, 45);
      check_seg("R6", base, model(ai, 1), model(aq, 1));
      check_seg("R6", base + 25, model(bi, 1), model(bq, 1));
   endtask

   task automatic t_gaps();
      int base = cap_i.size();
      ia_t bi = rnd_block(480, 20000), bq = rnd_block(480, 20000);
      drive(0, bi, bq, 2, -1, 0);
      drain();
      chk(cap_i.size() - base == 20, "R8", "gapped stream count", cap_i.size() - base, 20);
      check_seg("R8", base, model(bi, 0), model(bq, 0));
   endtask

   task automatic t_mode_hold();
      int base = cap_i.size();
      ia_t bi = rnd_block(480, 20000), bq = rnd_block(480, 20000);
      drive(0, bi, bq, 0, 100, 2);
      drain();
      chk(cap_i.size() - base == 20, "R9", "count after mid-block mode change", cap_i.size() - base, 20);
      check_seg("R9", base, model(bi, 0), model(bq, 0));
   endtask

   task automatic t_idle();
      int base = cap_i.size();
      repeat (40) @(negedge clk);
      chk(cap_i.size() == base, "R8", "outputs during idle", cap_i.size() - base, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_wide_full();
      t_wide_double();
      t_mid();
      t_narrow();
      t_narrow_alt();
      t_clip();
      t_isolation();
      t_gaps();
      t_mode_hold();
      t_idle();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      #(4 * 195000);
      if (!done) begin
         done = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule